// File: doc/BRIEF.md
# Mirrored Fast-RAM Address Decoder with Shadow-ROM Guard

This block sits between a 32-bit CPU address bus and the fast RAM on an accelerator card. It recognises two 128 MB address windows, a primary one and an alias one. In each window the RAM image repeats once per RAM size, so any address in either window maps to the RAM offset `addr mod RAM_SIZE`. Each access is qualified by an address strobe. The decode result comes out of registers one clock after that strobe.

The top 512 KB of the RAM can hold a working copy of the system ROM. While the shadow flag is high, ordinary writes into that top slice through the normal windows are flagged for discard. Writes made through a dedicated shadow window are not discarded. They still reach the RAM, and in shadow mode they also raise a strobe. That strobe tells the ROM region to take the same data at offset `ram_ofs[18:0]`.

By default the shadow window is only the last 512 KB of the alias span. A build parameter can instead make the top 512 KB of every repeat in both windows act as the shadow window. The RAM arrays themselves sit outside this block.

Top module: `mram_shadow_decode`

## Requirements
- R1: An address with bits [31:27] equal to 5'b01101 (0x68000000 to 0x6FFFFFFF) asserts `ram_sel` when strobed.
- R2: An address with bits [31:27] equal to 5'b01001 (0x48000000 to 0x4FFFFFFF) asserts `ram_sel` when strobed.
- R3: When `ram_sel` is high, `ram_ofs` equals the strobed address bits [RAM_LOG2-1:0], so the RAM repeats every RAM size in both windows.
- R4: An address outside both windows gives `ram_sel`, `wr_inhibit` and `mirror_stb` low and `ram_ofs` zero.
- R5: All outputs are registered. They reflect the inputs sampled at the previous rising clock edge. With `req` low, all outputs are low or zero. Synchronous reset clears all outputs.
- R6: With `shadow_on` high, a write through a normal window at an offset of RAM_SIZE-524288 or above asserts `wr_inhibit`. The same write one byte below that boundary does not.
- R7: Reads (`we` low) never assert `wr_inhibit` or `mirror_stb`.
- R8: With `shadow_on` low, no write asserts `wr_inhibit` or `mirror_stb`.
- R9: By default the shadow window is 0x4FF80000 to 0x4FFFFFFF. A write there with `shadow_on` high asserts `ram_sel` and `mirror_stb`, keeps `wr_inhibit` low, and gives `ram_ofs` in the top 512 KB. The ROM-side offset is `ram_ofs[18:0]`.
- R10: A write to the shadow window with `shadow_on` low asserts `ram_sel` with both `wr_inhibit` and `mirror_stb` low.
- R11: A cycle counts as a write only if `we` is high and at least one of `sz_byte`, `sz_word`, `sz_long` is high. Otherwise it causes no inhibit and no mirror.
- R12: With `MIRROR_EVERY_REPEAT` = 1, the top 512 KB of every repeat in both windows acts as the shadow window. A write there in shadow mode asserts `mirror_stb` rather than `wr_inhibit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Address strobe, one access per cycle |
| addr | input | ADDR_W | CPU byte address |
| sz_byte | input | 1 | Byte-size access |
| sz_word | input | 1 | Word-size access |
| sz_long | input | 1 | Long-size access |
| we | input | 1 | Write when high, read when low |
| shadow_on | input | 1 | Shadow-ROM mode active |
| ram_sel | output | 1 | Access falls in RAM |
| ram_ofs | output | RAM_LOG2 | Byte offset into RAM |
| wr_inhibit | output | 1 | Discard this write to RAM |
| mirror_stb | output | 1 | Copy this write into the ROM region at `ram_ofs[18:0]` |

## Verification
On every cycle, the assertions check the following:
- `ram_sel` only follows a strobe to one of the two windows.
- The offset tracks the strobed address.
- Inhibit and mirror never fire together.
- Inhibit and mirror fire only for writes into the top slice in shadow mode.

Only the bench scenarios can show the exact boundary behaviour: which addresses fall either side of the reserved slice, the dedicated window's exact extent, the role of the size strobes, and the every-repeat variant. Those scenarios drive chosen addresses and compare each registered result with an independently computed expectation.

// File: rtl/msd_pkg.sv
package msd_pkg;
  localparam int SHADOW_LOG2 = 19;   // 512 KB reserved slice

  typedef enum logic [1:0] {
    WIN_NONE   = 2'd0,
    WIN_NORMAL = 2'd1,
    WIN_SHADOW = 2'd2
  } win_kind_e;

  function automatic logic is_write(input logic we, input logic b,
                                    input logic w, input logic l);
    return we & (b | w | l);
  endfunction
endpackage

// File: rtl/msd_base_match.sv
module msd_base_match #(
  parameter int          ADDR_W    = 32,
  parameter int          SPAN_LOG2 = 27,
  parameter logic [31:0] BASE      = 32'h6800_0000
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam int TAG_W = ADDR_W - SPAN_LOG2;
  localparam logic [TAG_W-1:0] TAG = BASE[ADDR_W-1:SPAN_LOG2];

  assign hit = (addr[ADDR_W-1:SPAN_LOG2] == TAG);
endmodule

// File: rtl/msd_region_classify.sv
module msd_region_classify
  import msd_pkg::*;
#(
  parameter int          ADDR_W              = 32,
  parameter int          RAM_LOG2            = 24,
  parameter logic [31:0] SHADOW_WIN_BASE     = 32'h4FF8_0000,
  parameter bit          MIRROR_EVERY_REPEAT = 1'b0
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic                any_hit,
  output win_kind_e           kind,
  output logic                in_top,
  output logic [RAM_LOG2-1:0] ofs
);
  localparam int SW_TAG_W = ADDR_W - SHADOW_LOG2;
  localparam logic [SW_TAG_W-1:0] SW_TAG = SHADOW_WIN_BASE[ADDR_W-1:SHADOW_LOG2];

  logic shadow_hit;

  assign ofs    = any_hit ? addr[RAM_LOG2-1:0] : '0;
  assign in_top = any_hit & (&addr[RAM_LOG2-1:SHADOW_LOG2]);

  generate
    if (MIRROR_EVERY_REPEAT) begin : g_every
      assign shadow_hit = in_top;
    end else begin : g_single
      assign shadow_hit = any_hit & (addr[ADDR_W-1:SHADOW_LOG2] == SW_TAG);
    end
  endgenerate

  always_comb begin
    if (!any_hit)        kind = WIN_NONE;
    else if (shadow_hit) kind = WIN_SHADOW;
    else                 kind = WIN_NORMAL;
  end
endmodule

// File: rtl/msd_protect.sv
module msd_protect
  import msd_pkg::*;
(
  input  win_kind_e kind,
  input  logic      in_top,
  input  logic      we,
  input  logic      sz_byte,
  input  logic      sz_word,
  input  logic      sz_long,
  input  logic      shadow_on,
  output logic      inhibit,
  output logic      mirror
);
  logic wr;

  assign wr      = is_write(we, sz_byte, sz_word, sz_long);
  assign inhibit = shadow_on & wr & in_top & (kind == WIN_NORMAL);
  assign mirror  = shadow_on & wr & (kind == WIN_SHADOW);
endmodule

// File: rtl/mram_shadow_decode.sv
module mram_shadow_decode
  import msd_pkg::*;
#(
  parameter int          ADDR_W              = 32,
  parameter int          RAM_LOG2            = 24,
  parameter int          SPAN_LOG2           = 27,
  parameter logic [31:0] PRIMARY_BASE        = 32'h6800_0000,
  parameter logic [31:0] ALIAS_BASE          = 32'h4800_0000,
  parameter logic [31:0] SHADOW_WIN_BASE     = 32'h4FF8_0000,
  parameter bit          MIRROR_EVERY_REPEAT = 1'b0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                sz_byte,
  input  logic                sz_word,
  input  logic                sz_long,
  input  logic                we,
  input  logic                shadow_on,
  output logic                ram_sel,
  output logic [RAM_LOG2-1:0] ram_ofs,
  output logic                wr_inhibit,
  output logic                mirror_stb
);
  localparam int NUM_BASES = 2;
  localparam logic [NUM_BASES*32-1:0] BASES = {ALIAS_BASE, PRIMARY_BASE};

  logic [NUM_BASES-1:0] base_hit;
  logic                 any_hit;
  win_kind_e            kind;
  logic                 in_top;
  logic [RAM_LOG2-1:0]  ofs_c;
  logic                 inh_c, mir_c;

  generate
    for (genvar g = 0; g < NUM_BASES; g++) begin : g_base
      msd_base_match #(
        .ADDR_W   (ADDR_W),
        .SPAN_LOG2(SPAN_LOG2),
        .BASE     (BASES[g*32 +: 32])
      ) u_match (
        .addr(addr),
        .hit (base_hit[g])
      );
    end
  endgenerate

  assign any_hit = |base_hit;

  msd_region_classify #(
    .ADDR_W             (ADDR_W),
    .RAM_LOG2           (RAM_LOG2),
    .SHADOW_WIN_BASE    (SHADOW_WIN_BASE),
    .MIRROR_EVERY_REPEAT(MIRROR_EVERY_REPEAT)
  ) u_class (
    .addr   (addr),
    .any_hit(any_hit),
    .kind   (kind),
    .in_top (in_top),
    .ofs    (ofs_c)
  );

  msd_protect u_prot (
    .kind     (kind),
    .in_top   (in_top),
    .we       (we),
    .sz_byte  (sz_byte),
    .sz_word  (sz_word),
    .sz_long  (sz_long),
    .shadow_on(shadow_on),
    .inhibit  (inh_c),
    .mirror   (mir_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_sel    <= 1'b0;
      ram_ofs    <= '0;
      wr_inhibit <= 1'b0;
      mirror_stb <= 1'b0;
    end else begin
      ram_sel    <= req & any_hit;
      ram_ofs    <= req ? ofs_c : '0;
      wr_inhibit <= req & inh_c;
      mirror_stb <= req & mir_c;
    end
  end
endmodule

// File: rtl/msd_checker.sv
module msd_checker #(
  parameter int          ADDR_W       = 32,
  parameter int          RAM_LOG2     = 24,
  parameter int          SPAN_LOG2    = 27,
  parameter logic [31:0] PRIMARY_BASE = 32'h6800_0000,
  parameter logic [31:0] ALIAS_BASE   = 32'h4800_0000
) (
  input logic                clk,
  input logic                rst,
  input logic                req,
  input logic [ADDR_W-1:0]   addr,
  input logic                we,
  input logic                shadow_on,
  input logic                ram_sel,
  input logic [RAM_LOG2-1:0] ram_ofs,
  input logic                wr_inhibit,
  input logic                mirror_stb
);
  localparam int TAG_W = ADDR_W - SPAN_LOG2;
  localparam logic [TAG_W-1:0] PRI_TAG = PRIMARY_BASE[ADDR_W-1:SPAN_LOG2];
  localparam logic [TAG_W-1:0] ALI_TAG = ALIAS_BASE[ADDR_W-1:SPAN_LOG2];
  localparam int SH_LOG2 = 19;

  AST_SEL_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    ram_sel |-> $past(req));  // R5
  AST_SEL_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    ram_sel |-> ($past(addr[ADDR_W-1:SPAN_LOG2]) == PRI_TAG ||
                 $past(addr[ADDR_W-1:SPAN_LOG2]) == ALI_TAG));  // R4
  AST_OFS_TRACKS_ADDR: assert property (@(posedge clk) disable iff (rst)
    ram_sel |-> ram_ofs == $past(addr[RAM_LOG2-1:0]));  // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !ram_sel |-> (ram_ofs == '0 && !wr_inhibit && !mirror_stb));  // R4
  AST_INHIBIT_TOP: assert property (@(posedge clk) disable iff (rst)
    wr_inhibit |-> (ram_sel && (&ram_ofs[RAM_LOG2-1:SH_LOG2]) && $past(shadow_on)));  // R6
  AST_READ_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
    !$past(we) |-> (!wr_inhibit && !mirror_stb));  // R7
  AST_MODE_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    !$past(shadow_on) |-> (!wr_inhibit && !mirror_stb));  // R8
  AST_MIRROR_TOP: assert property (@(posedge clk) disable iff (rst)
    mirror_stb |-> (ram_sel && (&ram_ofs[RAM_LOG2-1:SH_LOG2]) && !wr_inhibit));  // R9
endmodule

bind mram_shadow_decode msd_checker #(
  .ADDR_W      (ADDR_W),
  .RAM_LOG2    (RAM_LOG2),
  .SPAN_LOG2   (SPAN_LOG2),
  .PRIMARY_BASE(PRIMARY_BASE),
  .ALIAS_BASE  (ALIAS_BASE)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req       (req),
  .addr      (addr),
  .we        (we),
  .shadow_on (shadow_on),
  .ram_sel   (ram_sel),
  .ram_ofs   (ram_ofs),
  .wr_inhibit(wr_inhibit),
  .mirror_stb(mirror_stb)
);

// File: tb/tb_mram_shadow_decode.sv
`timescale 1ns/1ps
module tb_mram_shadow_decode;
  localparam int RL = 24;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 1'b0;
  logic [31:0] addr = '0;
  logic sz_byte = 1'b0, sz_word = 1'b0, sz_long = 1'b0, we = 1'b0, shadow_on = 1'b0;

  logic          sel_a, inh_a, mir_a, sel_b, inh_b, mir_b;
  logic [RL-1:0] ofs_a, ofs_b;

  always #10 clk = ~clk;  // 50 MHz

  mram_shadow_decode #(.RAM_LOG2(RL)) dut (
    .clk(clk), .rst(rst), .req(req), .addr(addr),
    .sz_byte(sz_byte), .sz_word(sz_word), .sz_long(sz_long),
    .we(we), .shadow_on(shadow_on),
    .ram_sel(sel_a), .ram_ofs(ofs_a), .wr_inhibit(inh_a), .mirror_stb(mir_a));

  mram_shadow_decode #(.RAM_LOG2(RL), .MIRROR_EVERY_REPEAT(1'b1)) dut_rep (
    .clk(clk), .rst(rst), .req(req), .addr(addr),
    .sz_byte(sz_byte), .sz_word(sz_word), .sz_long(sz_long),
    .we(we), .shadow_on(shadow_on),
    .ram_sel(sel_b), .ram_ofs(ofs_b), .wr_inhibit(inh_b), .mirror_stb(mir_b));

  typedef struct {
    logic          sel;
    logic [RL-1:0] ofs;
    logic          inh;
    logic          mir;
    bit            rep;
    string         tag;
  } item_t;

  item_t q[$];
  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // Expected result computed from the requirement text.
  function automatic item_t model(input logic [31:0] a, input logic rq, input logic w,
                                  input logic b, input logic wd, input logic l,
                                  input logic sh, input bit rep, input string tag);
    item_t it;
    logic hit, top, win, wr;
    hit = rq && (a[31:27] == 5'b01101 || a[31:27] == 5'b01001);
    top = hit && (a[23:19] == 5'h1F);
    win = rep ? top : (hit && a[31:19] == 13'h09FF);
    wr  = w && (b || wd || l);
    it.sel = hit;
    it.ofs = hit ? a[RL-1:0] : '0;
    it.inh = hit && sh && wr && top && !win;
    it.mir = hit && sh && wr && win;
    it.rep = rep;
    it.tag = tag;
    return it;
  endfunction

  task automatic drive(input logic [31:0] a, input logic rq, input logic w,
                       input logic b, input logic wd, input logic l,
                       input logic sh, input bit rep, input string tag);
    @(negedge clk);
    addr = a; req = rq; we = w; sz_byte = b; sz_word = wd; sz_long = l; shadow_on = sh;
    q.push_back(model(a, rq, w, b, wd, l, sh, rep, tag));
  endtask

  // Monitor: outputs settle at the edge after the drive; compare shortly after.
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      item_t e;
      logic s, i, m;
      logic [RL-1:0] o;
      e = q.pop_front();
      s = e.rep ? sel_b : sel_a;
      o = e.rep ? ofs_b : ofs_a;
      i = e.rep ? inh_b : inh_a;
      m = e.rep ? mir_b : mir_a;
      n_checks++;
      if (s !== e.sel || o !== e.ofs || i !== e.inh || m !== e.mir) begin
        n_fail++;
        $display("FAIL %s: got sel=%0b ofs=%h inh=%0b mir=%0b, expected sel=%0b ofs=%h inh=%0b mir=%0b",
                 e.tag, s, o, i, m, e.sel, e.ofs, e.inh, e.mir);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(20 * 5000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R5: reset state
    n_checks++;
    if (sel_a !== 1'b0 || ofs_a !== '0 || inh_a !== 1'b0 || mir_a !== 1'b0) begin
      n_fail++;
      $display("FAIL R5 reset: got sel=%0b ofs=%h inh=%0b mir=%0b, expected 0 0 0 0",
               sel_a, ofs_a, inh_a, mir_a);
    end
    drive(32'h6800_1234, 1, 0, 0, 0, 1, 0, 0, "R1 primary read");
    drive(32'h6FFF_FFFC, 1, 0, 0, 0, 1, 0, 0, "R1 primary end");
    drive(32'h48AB_CDE0, 1, 0, 0, 1, 0, 0, 0, "R2 alias read");
    drive(32'h6B00_1234, 1, 0, 1, 0, 0, 0, 0, "R3 primary repeat");
    drive(32'h4D12_3456, 1, 0, 1, 0, 0, 0, 0, "R3 alias repeat");
    drive(32'h7000_0000, 1, 0, 0, 0, 1, 0, 0, "R4 above primary");
    drive(32'h47FF_FFFC, 1, 1, 0, 0, 1, 1, 0, "R4 below alias");
    drive(32'h00F8_0000, 1, 1, 1, 0, 0, 1, 0, "R4 low address");
    drive(32'h6800_1234, 0, 1, 0, 0, 1, 1, 0, "R5 no strobe");
    drive(32'h68F8_0000, 1, 1, 0, 0, 1, 1, 0, "R6 top write inhibited");
    drive(32'h68F7_FFFF, 1, 1, 1, 0, 0, 1, 0, "R6 boundary minus one");
    drive(32'h4AFF_FFFE, 1, 1, 0, 1, 0, 1, 0, "R6 alias repeat top");
    drive(32'h68F8_0000, 1, 0, 0, 0, 1, 1, 0, "R7 top read");
    drive(32'h4FF8_0010, 1, 0, 0, 0, 1, 1, 0, "R7 shadow window read");
    drive(32'h68F8_0000, 1, 1, 0, 0, 1, 0, 0, "R8 mode off write");
    drive(32'h4FF8_0010, 1, 1, 0, 0, 1, 1, 0, "R9 shadow window write");
    drive(32'h4FFF_FFFF, 1, 1, 1, 0, 0, 1, 0, "R9 shadow window end");
    drive(32'h4FF7_FFFE, 1, 1, 0, 1, 0, 1, 0, "R9 below shadow window");
    drive(32'h4FF8_0010, 1, 1, 0, 0, 1, 0, 0, "R10 shadow write mode off");
    drive(32'h68F8_0000, 1, 1, 0, 0, 0, 1, 0, "R11 no size strobe normal");
    drive(32'h4FF8_0010, 1, 1, 0, 0, 0, 1, 0, "R11 no size strobe shadow");
    drive(32'h68F8_0000, 1, 1, 0, 0, 1, 1, 1, "R12 every repeat mirror");
    drive(32'h4AFF_FFFE, 1, 1, 0, 1, 0, 1, 1, "R12 alias repeat mirror");
    drive(32'h68F7_FFFC, 1, 1, 0, 0, 1, 1, 1, "R12 below top");
    drive(32'h0000_0000, 0, 0, 0, 0, 0, 0, 0, "R5 idle");
    repeat (3) @(posedge clk);
    #5;
    finish_run();
  end
endmodule